// File: doc/BRIEF.md
# Per-Channel Colour Gain Scaler

This block multiplies each 8-bit colour component of a pixel stream (red, green, blue) by its own unsigned fixed-point gain. Each gain has one integer bit and eight fractional bits. The colour is widened with a zero top bit and multiplied by the gain. The scaled colour is taken from product bits 15 down to 8, which is the integer part of the product with its two top integer bits dropped. The horizontal sync, vertical sync and data-enable signals pass through a delay line of the same length as the colour path, so the timing stays aligned at the output.

The gains are adjusted at run time. A three-bit select input marks which channels take part, and a direction input chooses up or down. A single-cycle step pulse, which is expected to arrive already debounced, moves every selected gain by one least-significant step (1/256). After reset every gain is unity. A gain never rises above unity and never falls below zero.

Top module: `chan_gain_scaler`

## Requirements
- R1: After reset every gain equals unity (9'h100), so each colour output equals its input, delayed by the pipeline latency.
- R2: Each colour output equals bits 15:8 of the 18-bit product of {1'b0, colour} and that channel's gain.
- R3: Colour and sync outputs appear 2 clock cycles after their inputs are sampled. hs_out, vs_out and de_out carry hs_in, vs_in and de_in with the same delay.
- R4: A clock edge with step_in high, dir_in low (up) and a channel's select bit set raises that gain by 1. If the gain is already at unity it stays at unity.
- R5: A clock edge with step_in high, dir_in high (down) and a channel's select bit set lowers that gain by 1. If the gain is already 0 it stays at 0.
- R6: A gain keeps its value on any edge where step_in is low or its select bit (bit 0 red, bit 1 green, bit 2 blue) is clear.
- R7: A gain change made at a clock edge applies to pixels sampled at later edges. The pixel sampled at the same edge still uses the old gain.
- R8: While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| r_in | input | 8 | Red component in |
| g_in | input | 8 | Green component in |
| b_in | input | 8 | Blue component in |
| hs_in | input | 1 | Horizontal sync in |
| vs_in | input | 1 | Vertical sync in |
| de_in | input | 1 | Data enable in |
| sel_in | input | 3 | Channel select for stepping: bit 0 red, bit 1 green, bit 2 blue |
| dir_in | input | 1 | Step direction: 0 up, 1 down |
| step_in | input | 1 | Single-cycle debounced step pulse |
| r_out | output | 8 | Scaled red |
| g_out | output | 8 | Scaled green |
| b_out | output | 8 | Scaled blue |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |
| de_out | output | 1 | Delayed data enable |

## Verification
A pixel and its sync bits driven before clock edge N appear at the outputs after edge N+1. The bench therefore compares each cycle's outputs with the expectation it computed one stimulus step earlier. A step pulse changes the gain at the same edge that samples the accompanying pixel. The bench model therefore computes that pixel's expectation with the old gain and only then applies the step. This places the effect of the new gain exactly one pixel later. Long runs of steps drive gains to both saturation limits. Unity-gain pixels and pixels of value 255 make any gain error visible at the colour outputs.

// File: rtl/chan_gain_pkg.sv
`timescale 1ns/1ps
package chan_gain_pkg;
  localparam int NUM_CH = 3;
  typedef enum logic {
    STEP_UP   = 1'b0,
    STEP_DOWN = 1'b1
  } step_dir_e;
endpackage

// File: rtl/gain_step_reg.sv
`timescale 1ns/1ps
module gain_step_reg
  import chan_gain_pkg::*;
#(
  parameter int FRAC_W = 8,
  localparam int GAIN_W = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              sel_i,
  input  logic              down_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC_W;

  logic [GAIN_W-1:0] gain_q, gain_d;
  logic              upd_en;

  assign upd_en = step_i & sel_i;

  always_comb begin
    gain_d = gain_q;
    if (down_i == STEP_DOWN) begin
      if (gain_q != '0) gain_d = gain_q - GAIN_W'(1);
    end else begin
      if (gain_q < UNITY) gain_d = gain_q + GAIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gain_q <= UNITY;
    else if (upd_en) gain_q <= gain_d;
  end

  assign gain_o = gain_q;

  // R4
  gain_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= UNITY);

  // R4
  gain_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && sel_i && !down_i && gain_q != UNITY) |=>
      gain_q == GAIN_W'($past(gain_q) + 1));

  // R5
  gain_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && sel_i && down_i && gain_q != '0) |=>
      gain_q == GAIN_W'($past(gain_q) - 1));

  // R6
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_i && sel_i) |=> $stable(gain_q));
endmodule

// File: rtl/pixel_scale_stage.sv
`timescale 1ns/1ps
module pixel_scale_stage #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8,
  localparam int GAIN_W = FRAC_W + 1,
  localparam int PROD_W = PIX_W + 1 + GAIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic [PROD_W-1:0] prod;
  logic [PIX_W-1:0]  pix_d, pix_q;

  always_comb begin
    prod  = PROD_W'({1'b0, pix_i}) * PROD_W'(gain_i);
    pix_d = prod[FRAC_W +: PIX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_d;
  end

  assign pix_o = pix_q;

  // R2
  scaled_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_q <= $past(pix_i));
endmodule

// File: rtl/pipe_delay.sv
`timescale 1ns/1ps
module pipe_delay #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_pipe
      logic [WIDTH-1:0] stg [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= din;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
          end
        end
      end
      assign dout = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/chan_gain_scaler.sv
`timescale 1ns/1ps
module chan_gain_scaler
  import chan_gain_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int FRAC_W     = 8,
  parameter int OUT_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] r_in,
  input  logic [PIX_W-1:0] g_in,
  input  logic [PIX_W-1:0] b_in,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             de_in,
  input  logic [2:0]       sel_in,
  input  logic             dir_in,
  input  logic             step_in,
  output logic [PIX_W-1:0] r_out,
  output logic [PIX_W-1:0] g_out,
  output logic [PIX_W-1:0] b_out,
  output logic             hs_out,
  output logic             vs_out,
  output logic             de_out
);
  localparam int GAIN_W  = FRAC_W + 1;
  localparam int LATENCY = 1 + OUT_STAGES;
  localparam int CW      = NUM_CH * PIX_W;

  logic [NUM_CH-1:0][PIX_W-1:0]  pix_in_a, pix_sc_a, pix_out_a;
  logic [NUM_CH-1:0][GAIN_W-1:0] gain_a;

  assign pix_in_a[0] = r_in;
  assign pix_in_a[1] = g_in;
  assign pix_in_a[2] = b_in;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      gain_step_reg #(.FRAC_W(FRAC_W)) u_gain (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_in),
        .sel_i  (sel_in[c]),
        .down_i (dir_in),
        .gain_o (gain_a[c])
      );
      pixel_scale_stage #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_scale (
        .clk    (clk),
        .rst_n  (rst_n),
        .pix_i  (pix_in_a[c]),
        .gain_i (gain_a[c]),
        .pix_o  (pix_sc_a[c])
      );
    end
  endgenerate

  pipe_delay #(.WIDTH(CW), .DEPTH(OUT_STAGES)) u_pix_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pix_sc_a),
    .dout  (pix_out_a)
  );

  pipe_delay #(.WIDTH(3), .DEPTH(LATENCY)) u_sync_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({hs_in, vs_in, de_in}),
    .dout  ({hs_out, vs_out, de_out})
  );

  assign r_out = pix_out_a[0];
  assign g_out = pix_out_a[1];
  assign b_out = pix_out_a[2];
endmodule

// File: tb/tb_chan_gain_scaler.sv
`timescale 1ns/1ps
module tb_chan_gain_scaler;
  logic       clk, rst_n;
  logic [7:0] r_in, g_in, b_in, r_out, g_out, b_out;
  logic       hs_in, vs_in, de_in, hs_out, vs_out, de_out;
  logic [2:0] sel_in;
  logic       dir_in, step_in;

  int checks = 0;
  int errors = 0;
  int gm [3];
  logic [26:0] prev_exp;
  bit          prev_valid;

  chan_gain_scaler dut (
    .clk(clk), .rst_n(rst_n),
    .r_in(r_in), .g_in(g_in), .b_in(b_in),
    .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .sel_in(sel_in), .dir_in(dir_in), .step_in(step_in),
    .r_out(r_out), .g_out(g_out), .b_out(b_out),
    .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] scale(input int pix, input int g);
    return 8'(((pix * g) >> 8) & 255);
  endfunction

  function automatic int clampg(input int g);
    if (g < 0) return 0;
    if (g > 256) return 256;
    return g;
  endfunction

  task automatic check(input string tag, input logic [26:0] act, input logic [26:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one pixel per call; outputs checked against the previous call's expectation
  task automatic tick(input string tag, input int r, input int g, input int b,
                      input logic [2:0] syn, input logic [2:0] sel,
                      input logic dir, input logic stp);
    logic [26:0] cur;
    r_in = 8'(r); g_in = 8'(g); b_in = 8'(b);
    {hs_in, vs_in, de_in} = syn;
    sel_in = sel; dir_in = dir; step_in = stp;
    cur = {scale(r, gm[0]), scale(g, gm[1]), scale(b, gm[2]), syn};
    @(posedge clk);
    @(negedge clk);
    if (prev_valid)
      check(tag, {r_out, g_out, b_out, hs_out, vs_out, de_out}, prev_exp);
    prev_exp   = cur;
    prev_valid = 1'b1;
    if (stp) begin
      for (int c = 0; c < 3; c++)
        if (sel[c]) gm[c] = clampg(gm[c] + (dir ? -1 : 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 1'b0;
    r_in = 8'hff; g_in = 8'hff; b_in = 8'hff;
    {hs_in, vs_in, de_in} = 3'b111;
    sel_in = 3'b111; dir_in = 1'b0; step_in = 1'b0;
    for (int c = 0; c < 3; c++) gm[c] = 256;
    prev_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs held at zero in reset
    check("R8", {r_out, g_out, b_out, hs_out, vs_out, de_out}, 27'd0);
    rst_n = 1'b1;

    // R1: unity gains pass colour through
    tick("R1", 255, 0, 128, 3'b000, 3'b000, 1'b0, 1'b0);
    tick("R1", 1, 254, 77, 3'b000, 3'b000, 1'b0, 1'b0);
    tick("R1", 200, 100, 50, 3'b000, 3'b000, 1'b0, 1'b0);
    // R3: sync bits track with the colour latency
    tick("R3", 10, 20, 30, 3'b100, 3'b000, 1'b0, 1'b0);
    tick("R3", 40, 50, 60, 3'b010, 3'b000, 1'b0, 1'b0);
    tick("R3", 70, 80, 90, 3'b001, 3'b000, 1'b0, 1'b0);
    tick("R3", 11, 12, 13, 3'b101, 3'b000, 1'b0, 1'b0);
    // R4: stepping up at unity stays at unity
    tick("R4", 255, 255, 255, 3'b001, 3'b111, 1'b0, 1'b1);
    tick("R4", 255, 255, 255, 3'b001, 3'b000, 1'b0, 1'b0);
    // R5 R6: red only goes down; R7: same-edge pixel uses old gain
    for (int i = 0; i < 10; i++)
      tick("R5 R6 R7", 255, 255, 255, 3'b001, 3'b001, 1'b1, 1'b1);
    // R6: no step pulse means no change
    for (int i = 0; i < 5; i++)
      tick("R6", 255, 255, 255, 3'b001, 3'b111, 1'b1, 1'b0);
    // R5: drive blue below zero
    for (int i = 0; i < 300; i++)
      tick("R5", 255, 200, 255, 3'b011, 3'b100, 1'b1, 1'b1);
    tick("R5", 255, 200, 255, 3'b011, 3'b000, 1'b0, 1'b0);
    // R4: bring blue back above unity
    for (int i = 0; i < 300; i++)
      tick("R4", 255, 200, 255, 3'b011, 3'b100, 1'b0, 1'b1);
    tick("R4", 255, 200, 255, 3'b011, 3'b000, 1'b0, 1'b0);
    // R2: random pixels with random gain stepping
    for (int i = 0; i < 4000; i++) begin
      logic stp;
      stp = (($urandom % 4) == 0);
      tick("R2", int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
           3'($urandom), 3'($urandom), 1'($urandom % 8 < 5), stp);
    end
    tick("R2", 0, 0, 0, 3'b000, 3'b000, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule